// File: doc/BRIEF.md
# Quarter-Rate IF I/Q Demodulator

This block turns a stream of real, signed ADC samples of an intermediate-frequency carrier into baseband in-phase (I) and quadrature (Q) words. The sample clock runs at exactly four times the IF and is locked to the RF reference. Each sample therefore lands on a fixed carrier phase: 0, 90, 180 or 270 degrees. Demodulation needs no multipliers. A rotating two-bit phase index decides whether a sample feeds I or Q, and whether its sign is kept or flipped.

The most recent I and Q values are held. In the default full-rate variant, a fresh pair leaves the block on every accepted sample, so one component is always one sample older than the other. A parameter selects a pair-rate variant instead. It emits only after the Q sample that completes an I/Q pair, which gives one output every two accepted samples. A phase-reset pulse forces the rotation back to its start, so the I/Q reference axis is repeatable from run to run.

Top module: `iq_quarter_demod`

## Requirements
- R1: While reset is asserted and right after it, `dm_i` and `dm_q` are 0, `dm_valid` is 0, and the next accepted sample uses phase index 0.
- R2: Accepted samples take the phase indices 0,1,2,3,0,... in order. The sample at index 0 becomes +I, index 1 becomes +Q, index 2 becomes −I and index 3 becomes −Q.
- R3: An accepted sample updates only its own component; the other output component keeps its previous value.
- R4: In the full-rate variant (`PAIR_RATE`=0), every accepted sample produces `dm_valid`=1 with its result exactly two rising edges after the edge that captured it, including back-to-back samples.
- R5: A cycle with `smp_valid`=0 and no phase reset does not advance the phase index, does not change `dm_i`/`dm_q`, and produces no `dm_valid` two edges later.
- R6: `phase_zero`=1 forces the phase index to 0. If a sample is accepted in the same cycle, that sample is treated as index 0 and the next one as index 1.
- R7: Negating the most negative sample (−8192 for 14 bits) yields the most positive value (+8191) instead of wrapping.
- R8: In the pair-rate variant (`PAIR_RATE`=1), `dm_valid` pulses only for samples at phase index 1 or 3, with the same two-edge latency, and carries the current held I and Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample on `smp_data` is accepted this cycle |
| smp_data | input | SMP_W | Signed two's-complement IF sample |
| phase_zero | input | 1 | Force phase index to 0 |
| dm_i | output | SMP_W | Signed in-phase result |
| dm_q | output | SMP_W | Signed quadrature result |
| dm_valid | output | 1 | Result pair valid |

## Verification
The hardest case to reach from the ports is a sample accepted in the same cycle as a phase reset while the rotation is mid-way. In that case the sample must be mapped as index 0 and not as the index it would otherwise have taken. The stimulus table first advances the rotation to index 3 and then drives a sample together with `phase_zero`. A directed test also pulses `phase_zero` alone at index 2 and sends a sample afterwards, so a sign error on the following I value exposes a missed reset. The most negative code is applied at both a negating index and a non-negating index, so saturation is checked without disturbing the pass-through path.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    // Carrier phase of a sample taken at four times the IF
    typedef enum logic [1:0] {
        PH_I_POS = 2'd0,
        PH_Q_POS = 2'd1,
        PH_I_NEG = 2'd2,
        PH_Q_NEG = 2'd3
    } iqd_phase_e;

endpackage

// File: rtl/iqd_phase_ctr.sv
module iqd_phase_ctr
    import iqd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic       phase_zero,
    output iqd_phase_e cur_phase
);

    typedef struct packed {
        iqd_phase_e phase;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [1:0] nxt_idx;

    always_comb begin
        cur_phase = phase_zero ? PH_I_POS : st_q.phase;
        nxt_idx   = 2'(cur_phase) + 2'd1;
        st_d      = st_q;
        if (phase_zero) begin
            st_d.phase = PH_I_POS;
        end
        if (smp_valid) begin
            st_d.phase = iqd_phase_e'(nxt_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_I_POS};
        end else begin
            st_q <= st_d;
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !phase_zero) |=> (2'(st_q.phase) == 2'($past(st_q.phase) + 2'd1))); // R2
    AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_zero && !smp_valid) |=> (st_q.phase == PH_I_POS)); // R6
    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !phase_zero) |=> $stable(st_q.phase)); // R5

endmodule

// File: rtl/iqd_sign_map.sv
module iqd_sign_map
    import iqd_pkg::*;
#(
    parameter int SMP_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  iqd_phase_e              cur_phase,
    output logic                    s1_valid,
    output logic                    s1_is_q,
    output logic                    s1_pair_done,
    output logic signed [SMP_W-1:0] s1_val
);

    localparam logic signed [SMP_W-1:0] SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic signed [SMP_W-1:0] SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};

    typedef struct packed {
        logic                    valid;
        logic                    is_q;
        logic                    pair_done;
        logic signed [SMP_W-1:0] val;
    } map_state_t;

    map_state_t st_d, st_q;
    logic signed [SMP_W-1:0] neg_val;
    logic                    do_neg;

    always_comb begin
        do_neg  = (cur_phase == PH_I_NEG) || (cur_phase == PH_Q_NEG);
        neg_val = (smp_data == SMP_MIN) ? SMP_MAX : -smp_data;
        st_d    = st_q;
        st_d.valid = smp_valid;
        if (smp_valid) begin
            st_d.is_q      = (cur_phase == PH_Q_POS) || (cur_phase == PH_Q_NEG);
            st_d.pair_done = st_d.is_q;
            st_d.val       = do_neg ? neg_val : smp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid     = st_q.valid;
    assign s1_is_q      = st_q.is_q;
    assign s1_pair_done = st_q.pair_done;
    assign s1_val       = st_q.val;

    AST_NEG_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (cur_phase == PH_I_NEG || cur_phase == PH_Q_NEG) && smp_data == SMP_MIN)
        |=> (s1_val == SMP_MAX)); // R7
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> s1_valid); // R4

endmodule

// File: rtl/iqd_hold.sv
module iqd_hold #(
    parameter int SMP_W     = 14,
    parameter bit PAIR_RATE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_valid,
    input  logic                    s1_is_q,
    input  logic                    s1_pair_done,
    input  logic signed [SMP_W-1:0] s1_val,
    output logic signed [SMP_W-1:0] dm_i,
    output logic signed [SMP_W-1:0] dm_q,
    output logic                    dm_valid
);

    typedef struct packed {
        logic signed [SMP_W-1:0] i_hold;
        logic signed [SMP_W-1:0] q_hold;
        logic signed [SMP_W-1:0] out_i;
        logic signed [SMP_W-1:0] out_q;
        logic                    out_valid;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        emit;

    generate
        if (PAIR_RATE) begin : g_pair
            assign emit = s1_valid && s1_pair_done;
        end else begin : g_full
            assign emit = s1_valid;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (s1_valid) begin
            if (s1_is_q) begin
                st_d.q_hold = s1_val;
            end else begin
                st_d.i_hold = s1_val;
            end
        end
        st_d.out_valid = emit;
        if (emit) begin
            st_d.out_i = st_d.i_hold;
            st_d.out_q = st_d.q_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dm_i     = st_q.out_i;
    assign dm_q     = st_q.out_q;
    assign dm_valid = st_q.out_valid;

    AST_Q_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_is_q) |=> $stable(st_q.q_hold)); // R3
    AST_I_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_is_q) |=> $stable(st_q.i_hold)); // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !dm_valid); // R5

endmodule

// File: rtl/iq_quarter_demod.sv
module iq_quarter_demod
    import iqd_pkg::*;
#(
    parameter int SMP_W     = 14,
    parameter bit PAIR_RATE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    phase_zero,
    output logic signed [SMP_W-1:0] dm_i,
    output logic signed [SMP_W-1:0] dm_q,
    output logic                    dm_valid
);

    iqd_phase_e              cur_phase;
    logic                    s1_valid;
    logic                    s1_is_q;
    logic                    s1_pair_done;
    logic signed [SMP_W-1:0] s1_val;

    iqd_phase_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .phase_zero (phase_zero),
        .cur_phase  (cur_phase)
    );

    iqd_sign_map #(.SMP_W(SMP_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .cur_phase    (cur_phase),
        .s1_valid     (s1_valid),
        .s1_is_q      (s1_is_q),
        .s1_pair_done (s1_pair_done),
        .s1_val       (s1_val)
    );

    iqd_hold #(.SMP_W(SMP_W), .PAIR_RATE(PAIR_RATE)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .s1_valid     (s1_valid),
        .s1_is_q      (s1_is_q),
        .s1_pair_done (s1_pair_done),
        .s1_val       (s1_val),
        .dm_i         (dm_i),
        .dm_q         (dm_q),
        .dm_valid     (dm_valid)
    );

    generate
        if (!PAIR_RATE) begin : g_full_chk
            AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
                s1_valid |=> dm_valid); // R4
        end else begin : g_pair_chk
            AST_PAIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                (s1_valid && !s1_is_q) |=> !dm_valid); // R8
        end
    endgenerate

endmodule

// File: tb/test_iq_quarter_demod.sv
`timescale 1ns/1ps
module test_iq_quarter_demod;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [13:0] smp_data = '0;
    logic              phase_zero = 1'b0;
    logic signed [13:0] f_i, f_q, h_i, h_q;
    logic              f_v, h_v;
    int                total = 0;
    int                bad = 0;

    always #2.5 clk = ~clk;

    iq_quarter_demod #(.SMP_W(14), .PAIR_RATE(1'b0)) i_iq_quarter_demod (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .phase_zero(phase_zero), .dm_i(f_i), .dm_q(f_q), .dm_valid(f_v));

    iq_quarter_demod #(.SMP_W(14), .PAIR_RATE(1'b1)) i_iq_quarter_demod_pair (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .phase_zero(phase_zero), .dm_i(h_i), .dm_q(h_q), .dm_valid(h_v));

    // Stimulus: phase reset, sample; expected I, Q, pair-rate valid
    localparam int NV = 10;
    localparam int V_PZ [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
    localparam int V_S  [NV] = '{100, -50, 30, -8192, -8192, 8191, 8191, 7, -1, 0};
    localparam int V_I  [NV] = '{100, 100, -30, -30, -8192, -8192, -8191, 7, 7, 0};
    localparam int V_Q  [NV] = '{0, -50, -50, 8191, 8191, 8191, 8191, 8191, -1, -1};
    localparam int V_HV [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 1, 0};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; phase_zero = 1'b0;
        @(negedge clk);
        chk("R1 i in reset", int'(f_i), 0);
        chk("R1 q in reset", int'(f_q), 0);
        chk("R1 valid in reset", int'(f_v), 0);
        chk("R1 pair valid in reset", int'(h_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One isolated sample, checked two rising edges after capture
    task automatic one_sample(input logic pz, input int s);
        @(negedge clk);
        smp_valid = 1'b1; phase_zero = pz; smp_data = 14'(s);
        @(negedge clk);
        smp_valid = 1'b0; phase_zero = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: R2 sign/selection, R3 hold, R6 reset with sample, R7 saturation, R8 pair rate
        for (int k = 0; k < NV; k++) begin
            one_sample(V_PZ[k] != 0, V_S[k]);
            chk($sformatf("R2 R6 R7 vec%0d i", k), int'(f_i), V_I[k]);
            chk($sformatf("R3 R7 vec%0d q", k), int'(f_q), V_Q[k]);
            chk($sformatf("R4 vec%0d valid", k), int'(f_v), 1);
            chk($sformatf("R8 vec%0d pair valid", k), int'(h_v), V_HV[k]);
            if (V_HV[k] != 0) begin
                chk($sformatf("R8 vec%0d pair i", k), int'(h_i), V_I[k]);
                chk($sformatf("R8 vec%0d pair q", k), int'(h_q), V_Q[k]);
            end
        end

        // R1: reset mid-run clears outputs and phase
        do_reset();
        chk("R1 i after reset", int'(f_i), 0);
        chk("R1 valid after reset", int'(f_v), 0);

        // R4: back-to-back samples 10,20,30,40 from phase 0
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (n == 2) begin
                chk("R4 stream0 i", int'(f_i), 10);  chk("R4 stream0 q", int'(f_q), 0);
                chk("R4 stream0 v", int'(f_v), 1);
            end
            if (n == 3) begin
                chk("R4 stream1 i", int'(f_i), 10);  chk("R4 stream1 q", int'(f_q), 20);
                chk("R4 stream1 v", int'(f_v), 1);
            end
            if (n == 4) begin
                chk("R4 stream2 i", int'(f_i), -30); chk("R4 stream2 q", int'(f_q), 20);
                chk("R4 stream2 v", int'(f_v), 1);
            end
            if (n == 5) begin
                chk("R4 stream3 i", int'(f_i), -30); chk("R4 stream3 q", int'(f_q), -40);
                chk("R4 stream3 v", int'(f_v), 1);
            end
            smp_valid = (n < 4);
            smp_data  = 14'((n + 1) * 10);
        end
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 stream idle v", int'(f_v), 0);

        // R5: sample without valid is ignored
        @(negedge clk);
        smp_data = 14'(999);
        @(negedge clk);
        @(negedge clk);
        chk("R5 ignored v", int'(f_v), 0);
        chk("R5 ignored i", int'(f_i), -30);
        chk("R5 ignored q", int'(f_q), -40);
        one_sample(1'b0, 5);
        chk("R5 phase not advanced i", int'(f_i), 5);
        chk("R5 phase not advanced q", int'(f_q), -40);

        // R6: phase reset alone at index 2
        one_sample(1'b0, 6);
        chk("R6 pre q", int'(f_q), 6);
        @(negedge clk);
        phase_zero = 1'b1;
        @(negedge clk);
        phase_zero = 1'b0;
        one_sample(1'b0, 9);
        chk("R6 index0 after reset i", int'(f_i), 9);
        chk("R6 index0 after reset q", int'(f_q), 6);
        one_sample(1'b0, 11);
        chk("R6 then index1 q", int'(f_q), 11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule